// File: doc/BRIEF.md
# Two-Channel Start/Stop Edge Capture Timer

This block measures the timing of external signals with two independent channels. Each channel picks one of several input pins and watches it for a start condition and a stop condition. Each condition is programmed separately as a rising edge, a falling edge, either edge or never. Each channel owns a 16-bit counter that advances on an external counting tick. In the chosen operating mode, the counter value is copied into a capture register when an event occurs.

The pins are asynchronous. They pass through a two-flop synchroniser before edge detection. Each start or stop event sets a sticky flag in a shared status register, and an enabled flag drives the interrupt request. Hardware never zeroes a counter: software clears it through a strobe bit. The capture register is read low byte first. Reading the low byte freezes the high byte, so the two halves always come from the same capture.

Software drives the block over a simple byte-wide register bus, with the select, write enable, address and write data all sampled on the clock edge. Read data is combinational from the address. Read side effects take place on the clock edge of the read cycle.

Top module: `capture_timer`

## Requirements
- R1: A pin change is synchronised through two flops and then edge-detected. The resulting event acts on the channel no later than the third rising clock edge after the change. Edge codes are: 00 never, 01 rising, 10 falling, 11 either edge.
- R2: Each channel has a source register at address 4+4c+1. Its bits [1:0] select the single pin used for both the start and the stop detection of that channel. Edges on other pins have no effect on the channel.
- R3: Each channel has a configuration register at address 4+4c. Its fields are mode [1:0], start edge [3:2] and stop edge [5:4]. It reads back with bits [7:6] as 0. With mode 00 (off), the counter holds its value and the channel raises no events.
- R4: Mode 01 (gated) works as follows:
  - A start edge while idle begins counting; this sets the start flag.
  - Ticks are counted only while counting.
  - A stop edge while counting latches the count, ends counting and sets the stop flag.
  - A start edge while counting, and a stop edge while idle, are ignored.
- R5: In mode 10, the counter runs on every tick. Both the start edge and the stop edge latch the count and set their flag.
- R6: In mode 11, the counter runs on every tick. The stop edge latches the count and sets the stop flag. The start edge only sets the start flag.
- R7: The hardware never resets a counter. The counter wraps from 0xFFFF to 0x0000. Writing the configuration register with bit 7 set zeroes the counter, and bit 7 reads back as 0.
- R8: The status register is at address 0. It holds:
  - channel c start flag at bit 2c;
  - channel c stop flag at bit 2c+1;
  - channel c interrupt enable at bit 4+c, which is writable.
  
  Flags are sticky. A read of address 0 clears them, but an event in the same cycle wins.
- R9: irq_o is high exactly when some channel has a set flag and its enable bit is set.
- R10: The capture low byte is at address 4+4c+2 and the high byte at 4+4c+3. Reading the low byte stores the current high byte, and a read of the high byte returns that stored value.
- R11: The two channels share pins but count, capture and flag independently.
- R12: After reset, all configuration, flags, enables, counters and captures are zero, and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Counting tick; counters advance on clock edges where it is high |
| pins_i | input | 4 | Asynchronous candidate input pins |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write (1) or read (0) |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register |
| irq_o | output | 1 | Interrupt request |

## Verification
A counter that drifts, misses ticks or is zeroed by hardware shows up as a wrong capture value. The error is visible at the next latching event, and it persists across later captures, because no automatic reset hides it. A wrong run state in gated mode, or a misdecoded edge, appears as a missing or extra flag in the status register and as a wrong irq_o level within three clock cycles of the pin change. A broken high-byte hold shows up only when the capture changes between the two byte reads, so the stimulus places events there on purpose.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_GATED = 2'b01,
    MODE_BOTH  = 2'b10,
    MODE_STOP  = 2'b11
  } cap_mode_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  function automatic logic edge_hit(edge_sel_e sel, logic rise, logic fall);
    case (sel)
      EDGE_RISE: edge_hit = rise;
      EDGE_FALL: edge_hit = fall;
      EDGE_ANY:  edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/cap_sync_edge.sv
module cap_sync_edge #(
  parameter int NPIN = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] pins_i,
  output logic [NPIN-1:0] rise_o,
  output logic [NPIN-1:0] fall_o
);
  logic [NPIN-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pins_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~prev_q;
  assign fall_o = ~s2_q & prev_q;
endmodule

// File: rtl/cap_channel.sv
module cap_channel
  import cap_pkg::*;
#(
  parameter int CW   = 16,
  parameter int NPIN = 4,
  parameter int SW   = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [NPIN-1:0] rise_i,
  input  logic [NPIN-1:0] fall_i,
  input  cap_mode_e       mode_i,
  input  edge_sel_e       start_sel_i,
  input  edge_sel_e       stop_sel_i,
  input  logic [SW-1:0]   src_i,
  input  logic            clr_i,
  output logic [CW-1:0]   cnt_o,
  output logic [CW-1:0]   cap_o,
  output logic            run_o,
  output logic            start_evt_o,
  output logic            stop_evt_o
);
  logic r_sel, f_sel, st_hit, sp_hit, latch, counting;
  logic [CW-1:0] cnt_q, cap_q;
  logic run_q;

  assign r_sel  = rise_i[src_i];
  assign f_sel  = fall_i[src_i];
  assign st_hit = edge_hit(start_sel_i, r_sel, f_sel);
  assign sp_hit = edge_hit(stop_sel_i, r_sel, f_sel);

  always_comb begin
    start_evt_o = 1'b0;
    stop_evt_o  = 1'b0;
    counting    = 1'b0;
    latch       = 1'b0;
    unique case (mode_i)
      MODE_GATED: begin
        stop_evt_o  = sp_hit & run_q;
        start_evt_o = st_hit & ~run_q;
        counting    = tick_i & run_q;
        latch       = stop_evt_o;
      end
      MODE_BOTH: begin
        start_evt_o = st_hit;
        stop_evt_o  = sp_hit;
        counting    = tick_i;
        latch       = st_hit | sp_hit;
      end
      MODE_STOP: begin
        start_evt_o = st_hit;
        stop_evt_o  = sp_hit;
        counting    = tick_i;
        latch       = sp_hit;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cap_q <= '0;
      run_q <= 1'b0;
    end else begin
      if (clr_i)         cnt_q <= '0;
      else if (counting) cnt_q <= cnt_q + 1'b1;
      if (latch) cap_q <= cnt_q;
      if (mode_i != MODE_GATED) run_q <= 1'b0;
      else if (stop_evt_o)      run_q <= 1'b0;
      else if (start_evt_o)     run_q <= 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign cap_o = cap_q;
  assign run_o = run_q;
endmodule

// File: rtl/capture_timer.sv
module capture_timer
  import cap_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int NPIN = 4,
  parameter int CW   = 16,
  parameter int DW   = 8,
  parameter int AW   = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [NPIN-1:0] pins_i,
  input  logic            bus_sel_i,
  input  logic            bus_we_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [DW-1:0]   bus_wdata_i,
  output logic [DW-1:0]   bus_rdata_o,
  output logic            irq_o
);
  localparam int SW = (NPIN > 1) ? $clog2(NPIN) : 1;
  localparam int HW = CW - DW;
  localparam int FW = 2 * NCH;

  logic wr, rd, stat_rd;
  logic [NPIN-1:0] rise_w, fall_w;
  logic [NCH-1:0][1:0]    mode_q, start_q, stop_q;
  logic [NCH-1:0][SW-1:0] src_q;
  logic [NCH-1:0][HW-1:0] hold_q;
  logic [NCH-1:0][CW-1:0] cnt_w, cap_w;
  logic [NCH-1:0] run_w, clr_w, lo_rd, go_start_w, go_stop_w;
  logic [NCH-1:0] ie_q;
  logic [FW-1:0]  flag_q, flag_d;
  logic unused_wdata;

  assign wr      = bus_sel_i & bus_we_i;
  assign rd      = bus_sel_i & ~bus_we_i;
  assign stat_rd = rd & (bus_addr_i == '0);
  assign unused_wdata = ^bus_wdata_i;

  cap_sync_edge #(.NPIN(NPIN)) u_sync (
    .clk_i, .rst_ni, .pins_i, .rise_o(rise_w), .fall_o(fall_w)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [AW-1:0] BASE = AW'(4 * c + 4);
    logic cfg_wr;
    assign cfg_wr   = wr & (bus_addr_i == BASE);
    assign clr_w[c] = cfg_wr & bus_wdata_i[7];
    assign lo_rd[c] = rd & (bus_addr_i == BASE + AW'(2));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mode_q[c]  <= '0;
        start_q[c] <= '0;
        stop_q[c]  <= '0;
        src_q[c]   <= '0;
        hold_q[c]  <= '0;
      end else begin
        if (cfg_wr) begin
          mode_q[c]  <= bus_wdata_i[1:0];
          start_q[c] <= bus_wdata_i[3:2];
          stop_q[c]  <= bus_wdata_i[5:4];
        end
        if (wr && bus_addr_i == BASE + AW'(1)) src_q[c] <= bus_wdata_i[SW-1:0];
        if (lo_rd[c]) hold_q[c] <= cap_w[c][CW-1:DW];
      end
    end

    cap_channel #(.CW(CW), .NPIN(NPIN), .SW(SW)) u_chan (
      .clk_i, .rst_ni, .tick_i,
      .rise_i(rise_w), .fall_i(fall_w),
      .mode_i(cap_mode_e'(mode_q[c])),
      .start_sel_i(edge_sel_e'(start_q[c])),
      .stop_sel_i(edge_sel_e'(stop_q[c])),
      .src_i(src_q[c]), .clr_i(clr_w[c]),
      .cnt_o(cnt_w[c]), .cap_o(cap_w[c]), .run_o(run_w[c]),
      .start_evt_o(go_start_w[c]), .stop_evt_o(go_stop_w[c])
    );
  end

  // events win over the clearing read
  always_comb begin
    flag_d = stat_rd ? '0 : flag_q;
    for (int c = 0; c < NCH; c++) begin
      flag_d[2*c]   = flag_d[2*c] | go_start_w[c];
      flag_d[2*c+1] = flag_d[2*c+1] | go_stop_w[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      ie_q   <= '0;
    end else begin
      flag_q <= flag_d;
      if (wr && bus_addr_i == '0) ie_q <= bus_wdata_i[FW +: NCH];
    end
  end

  always_comb begin
    irq_o = 1'b0;
    for (int c = 0; c < NCH; c++)
      irq_o = irq_o | ((flag_q[2*c] | flag_q[2*c+1]) & ie_q[c]);
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == '0) bus_rdata_o[FW+NCH-1:0] = {ie_q, flag_q};
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr_i == AW'(4 * c + 4))
        bus_rdata_o[5:0] = {stop_q[c], start_q[c], mode_q[c]};
      if (bus_addr_i == AW'(4 * c + 5)) bus_rdata_o[SW-1:0] = src_q[c];
      if (bus_addr_i == AW'(4 * c + 6)) bus_rdata_o = cap_w[c][DW-1:0];
      if (bus_addr_i == AW'(4 * c + 7)) bus_rdata_o[HW-1:0] = hold_q[c];
    end
  end
endmodule

// File: rtl/cap_checker.sv
module cap_checker #(
  parameter int NCH = 2,
  parameter int CW  = 16,
  parameter int DW  = 8
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        tick_i,
  input logic                        stat_rd,
  input logic [2*NCH-1:0]            flag_q,
  input logic [NCH-1:0][1:0]         mode_q,
  input logic [NCH-1:0][CW-1:0]      cnt_w,
  input logic [NCH-1:0][CW-1:0]      cap_w,
  input logic [NCH-1:0][CW-DW-1:0]   hold_q,
  input logic [NCH-1:0]              run_w,
  input logic [NCH-1:0]              clr_w,
  input logic [NCH-1:0]              lo_rd,
  input logic [NCH-1:0]              go_start_w,
  input logic [NCH-1:0]              go_stop_w
);
  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R7
    no_auto_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_w[c] && !tick_i) |=> $stable(cnt_w[c]));
    // R3
    off_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q[c] == 2'b00 && !clr_w[c]) |=> $stable(cnt_w[c]));
    // R3
    off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q[c] == 2'b00) |-> !(go_start_w[c] || go_stop_w[c]));
    // R4
    gated_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q[c] == 2'b01 && !run_w[c] && !clr_w[c]) |=> $stable(cnt_w[c]));
    // R10
    hold_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lo_rd[c] |=> hold_q[c] == $past(cap_w[c][CW-1:DW]));
  end
  for (genvar i = 0; i < 2*NCH; i++) begin : g_f
    // R8
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[i] && !stat_rd) |=> flag_q[i]);
  end
endmodule

bind capture_timer cap_checker #(.NCH(NCH), .CW(CW), .DW(DW)) u_cap_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .stat_rd(stat_rd),
  .flag_q(flag_q), .mode_q(mode_q), .cnt_w(cnt_w), .cap_w(cap_w),
  .hold_q(hold_q), .run_w(run_w), .clr_w(clr_w), .lo_rd(lo_rd),
  .go_start_w(go_start_w), .go_stop_w(go_stop_w)
);

// File: tb/tb_capture_timer.sv
module tb_capture_timer;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, tick = 0, sel = 0, we = 0;
  logic [3:0] pins = '0, addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic irq;

  int n_chk = 0, n_fail = 0;
  int m_mode[2], m_st[2], m_sp[2], m_src[2], m_cnt[2], m_cap[2], m_hold[2];
  bit m_run[2];
  bit [3:0] m_flags = '0, m_pins = '0;
  bit [1:0] m_ie = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  capture_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .pins_i(pins),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); sel = 1; we = 1; addr = 4'(a); wdata = 8'(d);
    @(negedge clk); sel = 0; we = 0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk); sel = 1; we = 0; addr = 4'(a);
    #1 d = int'(rdata);
    @(negedge clk); sel = 0;
  endtask

  function automatic bit hit(int code, bit r);
    return (code == 1 && r) || (code == 2 && !r) || code == 3;
  endfunction

  task automatic cfg(int c, int mode, int st, int sp, int src, bit clr);
    wr(4 + 4*c, (int'(clr) << 7) | (sp << 4) | (st << 2) | mode);
    wr(5 + 4*c, src);
    m_mode[c] = mode; m_st[c] = st; m_sp[c] = sp; m_src[c] = src;
    if (mode != 1) m_run[c] = 0;
    if (clr) m_cnt[c] = 0;
  endtask

  task automatic ticks(int n);
    if (n > 0) begin
      @(negedge clk); tick = 1;
      repeat (n) @(negedge clk);
      tick = 0;
      for (int c = 0; c < 2; c++)
        if (m_mode[c] >= 2 || (m_mode[c] == 1 && m_run[c]))
          m_cnt[c] = (m_cnt[c] + n) & 16'hFFFF;
    end
  endtask

  task automatic set_pin(int p, bit v);
    bit st, sp;
    if (m_pins[p] != v) begin
      @(negedge clk); pins[p] = v; m_pins[p] = v;
      repeat (4) @(negedge clk);
      for (int c = 0; c < 2; c++) begin
        if (m_mode[c] != 0 && m_src[c] == p) begin
          st = hit(m_st[c], v); sp = hit(m_sp[c], v);
          case (m_mode[c])
            1: if (m_run[c] && sp) begin m_run[c] = 0; m_cap[c] = m_cnt[c]; m_flags[2*c+1] = 1; end
               else if (!m_run[c] && st) begin m_run[c] = 1; m_flags[2*c] = 1; end
            2: begin
                 if (st) begin m_cap[c] = m_cnt[c]; m_flags[2*c] = 1; end
                 if (sp) begin m_cap[c] = m_cnt[c]; m_flags[2*c+1] = 1; end
               end
            default: begin
                 if (st) m_flags[2*c] = 1;
                 if (sp) begin m_cap[c] = m_cnt[c]; m_flags[2*c+1] = 1; end
               end
          endcase
        end
      end
    end
  endtask

  task automatic chk_state(string req);
    int d;
    @(negedge clk); #1;
    check("R9 irq", int'(irq),
          int'((m_ie[0] && m_flags[1:0] != 0) || (m_ie[1] && m_flags[3:2] != 0)));
    for (int c = 0; c < 2; c++) begin
      rd(6 + 4*c, d); m_hold[c] = m_cap[c] >> 8;
      check({req, " cap lo"}, d, m_cap[c] & 8'hFF);
      rd(7 + 4*c, d);
      check("R10 cap hi", d, m_hold[c]);
    end
    rd(0, d);
    check({req, " R8 status"}, d, (int'(m_ie) << 4) | int'(m_flags));
    m_flags = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    int d;
    void'($urandom(32'h00C0FFEE));
    for (int c = 0; c < 2; c++) begin
      m_mode[c] = 0; m_st[c] = 0; m_sp[c] = 0; m_src[c] = 0;
      m_cnt[c] = 0; m_cap[c] = 0; m_hold[c] = 0; m_run[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R12 reset state
    check("R12 irq", int'(irq), 0);
    rd(4, d); check("R12 cfg0", d, 0);
    rd(9, d); check("R12 src1", d, 0);
    chk_state("R12");

    // R2 R6: ch0 stop-latch mode on pin 1, pin 0 ignored
    cfg(0, 3, 1, 2, 1, 1);
    rd(4, d); check("R3 cfg readback", d, 8'h27);
    ticks(10); set_pin(0, 1); set_pin(1, 1);
    ticks(7); set_pin(0, 0); set_pin(1, 0);
    check("R6 model cap", m_cap[0], 17);
    chk_state("R2 R6");

    // R4 R7 R11: ch1 gated on pin 2, no automatic reset between intervals
    cfg(1, 1, 1, 2, 2, 1);
    ticks(5); set_pin(2, 1); ticks(9); set_pin(2, 0);
    chk_state("R4 first");
    ticks(4); set_pin(2, 1); set_pin(2, 1); ticks(3); set_pin(2, 0);
    check("R4 model cap", m_cap[1], 12);
    chk_state("R4 R7 R11");

    // R5 R1: either-edge start and stop
    cfg(0, 2, 3, 3, 3, 1);
    ticks(3); set_pin(3, 1); ticks(4); set_pin(3, 0);
    check("R5 model cap", m_cap[0], 7);
    chk_state("R5 R1");

    // R3: channel off
    cfg(1, 0, 3, 3, 3, 0);
    ticks(6); set_pin(3, 1); set_pin(3, 0);
    chk_state("R3");

    // R9: enable and clearing
    wr(0, 8'h10); m_ie = 2'b01;
    set_pin(3, 1);
    chk_state("R9 set");
    set_pin(3, 0); wr(0, 0); m_ie = 0;
    chk_state("R9 masked");

    // R10: capture changes between byte reads
    cfg(0, 3, 0, 1, 0, 1);
    ticks(300); set_pin(0, 1); set_pin(0, 0);
    rd(6, d); check("R10 lo", d, 300 & 8'hFF);
    ticks(500); set_pin(0, 1); set_pin(0, 0);
    rd(7, d); check("R10 frozen hi", d, 300 >> 8);
    rd(6, d); check("R10 lo new", d, 800 & 8'hFF);
    rd(7, d); check("R10 hi new", d, 800 >> 8);
    m_flags = '0; rd(0, d);

    // R7: wrap
    cfg(0, 3, 0, 1, 0, 1);
    ticks(65537); set_pin(0, 1);
    check("R7 model wrap", m_cap[0], 1);
    chk_state("R7 wrap");
    set_pin(0, 0);
    chk_state("R7");

    // random
    for (int it = 0; it < 30; it++) begin
      int c = int'($urandom_range(1, 0));
      cfg(c, int'($urandom_range(3, 0)), int'($urandom_range(3, 0)),
          int'($urandom_range(3, 0)), int'($urandom_range(3, 0)), 1'($urandom_range(1, 0)));
      m_ie = 2'($urandom_range(3, 0)); wr(0, int'(m_ie) << 4);
      for (int k = 0; k < 6; k++) begin
        if ($urandom_range(1, 0) == 1) ticks(int'($urandom_range(40, 0)));
        else begin
          int p = int'($urandom_range(3, 0));
          set_pin(p, !m_pins[p]);
        end
      end
      chk_state("R11 random");
    end

    report();
    $finish;
  end
endmodule